// File: doc/BRIEF.md
# Successive-Approximation Trim Calibrator

This block finds a 12-bit trim word for an auxiliary DAC. That DAC adjusts the charge slope of an external integrator that filters a PWM pulse train. The search tests one bit per conversion cycle of the integrator, starting with the most significant bit. It writes a trial word and then waits for a strobe marking the end of the integrator-reset window. At that strobe it takes the resolved comparator level, which sets whether the bit under test survives. The comparator tells whether the held output sits above or below half the pulse amplitude.

While the search runs, the block drives its own PWM output at exactly half duty, which is the condition the comparator judges against. Once the last bit is decided, the block raises a single-cycle completion pulse and keeps the trim word applied. PWM duty control then passes to the user duty input. The analog path is external: integrator, sample-and-hold, comparator and trim DAC.

Top module: `trim_cal_top`

## Requirements
- R1: After reset, the trim word is 0, busy is 0, done is 0.
- R2: A start request while idle loads the trim word 100000000000 (only bit 11 set) and raises busy on the next clock edge. This also applies after an earlier calibration has finished.
- R3: At each cycle-done strobe while busy, the bit under test becomes the synchronized comparator level: 0 clears it and 1 keeps it.
- R4: After a decision on bit b > 0, bit b-1 is set to 1. All bits above b keep their decided values, and bits below b-1 stay 0.
- R5: The trim word changes only on an accepted start or a strobe while busy. A strobe while idle leaves it unchanged.
- R6: The strobe that decides bit 0 ends the search. On the next edge busy falls and done is high for exactly one cycle.
- R7: A start request while busy is ignored. The trim word and the search position are unchanged.
- R8: The comparator input passes through a two-flop synchronizer. A level change driven in the same cycle as the strobe is not seen by that decision.
- R9: While busy, the PWM output is high for PERIOD/2 clocks of every PERIOD-clock frame. The new duty takes effect at the next frame boundary.
- R10: While idle, the PWM high time per frame equals the user duty, and values at or above PERIOD give a constant high. The final trim word stays on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Request to begin a calibration |
| cmp_raw | input | 1 | Asynchronous comparator level (1 = keep bit) |
| cycle_done | input | 1 | One-cycle strobe at the end of the integrator-reset window |
| user_duty | input | PWM_CW | High clocks per frame used when idle |
| trim_code | output | CODE_W | Trim word for the auxiliary DAC |
| busy | output | 1 | High while the search runs |
| done | output | 1 | One-cycle pulse when the search ends |
| pwm_out | output | 1 | PWM pulse train |

## Verification
The assertions assume that cycle_done is synchronous to clk and lasts at most one cycle per conversion. They also assume that the comparator level is held stable for at least two clocks before the strobe whose decision it should steer. The bench models the comparator as "trial word not above a hidden target". It sets that level four clocks ahead of each strobe, so every random target should be recovered exactly. The one exception is a directed case that flips the comparator on the strobe cycle itself, to expose the synchronizer latency. Start requests and idle strobes are injected only as single-cycle pulses.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
   typedef enum logic {
      CAL_IDLE   = 1'b0,
      CAL_SEARCH = 1'b1
   } cal_state_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("trim_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/trim_sar.sv
module trim_sar
   import trim_cal_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmp,
   input  logic              strobe,
   output logic [CODE_W-1:0] code,
   output logic              busy,
   output logic              done
);
   localparam int IDX_W = $clog2(CODE_W);
   localparam logic [CODE_W-1:0] FIRST_TRIAL = {1'b1, {(CODE_W-1){1'b0}}};

   cal_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_nx;
   logic              done_q;

   generate
      if (CODE_W < 2) begin : g_bad
         $error("trim_sar needs CODE_W of at least 2");
      end
   endgenerate

   always_comb begin
      code_nx = code_q;
      code_nx[idx_q] = cmp;
      if (idx_q != '0) code_nx[idx_q - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CAL_IDLE;
         idx_q   <= '0;
         code_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q == CAL_IDLE) begin
            if (start) begin
               state_q <= CAL_SEARCH;
               idx_q   <= IDX_W'(CODE_W - 1);
               code_q  <= FIRST_TRIAL;
            end
         end else if (strobe) begin
            code_q <= code_nx;
            if (idx_q == '0) begin
               state_q <= CAL_IDLE;
               done_q  <= 1'b1;
            end else begin
               idx_q <= idx_q - 1'b1;
            end
         end
      end
   end

   assign code = code_q;
   assign busy = (state_q == CAL_SEARCH);
   assign done = done_q;

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && code == FIRST_TRIAL));

   assert_next_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && strobe && idx_q != '0) |=> code[$past(idx_q) - 1'b1]);

   assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(start && !busy) && !(busy && strobe)) |=> $stable(code));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !strobe) |=> ($stable(code) && busy));
endmodule

// File: rtl/trim_pwm.sv
module trim_pwm #(
   parameter int PERIOD = 100000,
   parameter int CW     = $clog2(PERIOD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          force_half,
   input  logic [CW-1:0] user_duty,
   output logic          pwm
);
   localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] duty_q;
   logic          half_q;
   logic [CW-1:0] duty_sel;

   generate
      if (PERIOD < 2) begin : g_bad
         $error("trim_pwm needs PERIOD of at least 2");
      end
   endgenerate

   assign duty_sel = force_half ? HALF : user_duty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= '0;
         half_q <= 1'b0;
      end else begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            duty_q <= duty_sel;
            half_q <= force_half;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm = (cnt_q < duty_q);

   assert_half_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (half_q && cnt_q == '0) |-> pwm);

   assert_half_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (half_q && cnt_q == HALF) |-> !pwm);
endmodule

// File: rtl/trim_cal_top.sv
module trim_cal_top #(
   parameter int CODE_W      = 12,
   parameter int PWM_PERIOD  = 100000,
   parameter int SYNC_STAGES = 2,
   parameter int PWM_CW      = $clog2(PWM_PERIOD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic              cmp_raw,
   input  logic              cycle_done,
   input  logic [PWM_CW-1:0] user_duty,
   output logic [CODE_W-1:0] trim_code,
   output logic              busy,
   output logic              done,
   output logic              pwm_out
);
   logic cmp_sync;

   trim_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (cmp_raw),
      .d_out (cmp_sync)
   );

   trim_sar #(.CODE_W(CODE_W)) u_sar (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cal_start),
      .cmp    (cmp_sync),
      .strobe (cycle_done),
      .code   (trim_code),
      .busy   (busy),
      .done   (done)
   );

   trim_pwm #(.PERIOD(PWM_PERIOD), .CW(PWM_CW)) u_pwm (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_half (busy),
      .user_duty  (user_duty),
      .pwm        (pwm_out)
   );

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (trim_code == '0 && !busy && !done));
endmodule

// File: tb/sim_trim_cal_top.sv
module sim_trim_cal_top;
   localparam int CODE_W = 12;
   localparam int PER    = 40;
   localparam int CW     = $clog2(PER + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_start = 1'b0;
   logic              cmp_raw = 1'b0;
   logic              cycle_done = 1'b0;
   logic [CW-1:0]     user_duty = '0;
   logic [CODE_W-1:0] trim_code;
   logic              busy;
   logic              done;
   logic              pwm_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   trim_cal_top #(.CODE_W(CODE_W), .PWM_PERIOD(PER)) u0 (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_raw(cmp_raw),
      .cycle_done(cycle_done), .user_duty(user_duty), .trim_code(trim_code),
      .busy(busy), .done(done), .pwm_out(pwm_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_trial(input int tgt, input int b);
      int keep_mask;
      keep_mask = ~((1 << (b + 1)) - 1) & 12'hFFF;
      return (tgt & keep_mask) | (1 << b);
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic measure_high(input int exp, input string req);
      int highs;
      highs = 0;
      repeat (2 * PER + 2) tick();
      for (int i = 0; i < PER; i++) begin
         tick();
         if (pwm_out) highs++;
      end
      check(highs == exp, req, highs, exp);
   endtask

   task automatic start_cal();
      tick(); cal_start = 1'b1;
      tick(); cal_start = 1'b0;
      check(busy == 1'b1 && trim_code == 12'h800, "R2", trim_code, 12'h800);
   endtask

   task automatic strobe();
      tick(); cycle_done = 1'b1;
      tick(); cycle_done = 1'b0;
   endtask

   task automatic run_cal(input int tgt, input bit poke_start, input bit check_pwm);
      start_cal();
      if (check_pwm) measure_high(PER / 2, "R9");
      for (int b = CODE_W - 1; b >= 0; b--) begin
         tick(); cmp_raw = (int'(trim_code) <= tgt);
         repeat (4) tick();
         if (poke_start && b == 6) begin
            tick(); cal_start = 1'b1;
            tick(); cal_start = 1'b0;
            check(busy && int'(trim_code) == exp_trial(tgt, 6), "R7",
                  trim_code, exp_trial(tgt, 6));
         end
         strobe();
         if (b > 0) begin
            check(int'(trim_code) == exp_trial(tgt, b - 1), "R3/R4 step",
                  trim_code, exp_trial(tgt, b - 1));
         end else begin
            check(int'(trim_code) == tgt, "R3 final", trim_code, tgt);
            check(!busy && done, "R6 end", {busy, done}, 1);
            tick();
            check(!done, "R6 pulse", done, 0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int tgt;
      int duty;
      void'($urandom(32'h5A17));
      repeat (3) tick();
      check(trim_code == '0 && !busy && !done, "R1", {trim_code, busy, done}, 0);
      rst_n = 1'b1;
      tick();
      check(trim_code == '0 && !busy && !done, "R1 post", {trim_code, busy, done}, 0);

      // directed corners
      run_cal(12'hFFF, 1'b0, 1'b1);
      run_cal(12'h000, 1'b1, 1'b0);
      run_cal(12'hA5C, 1'b1, 1'b0);

      // idle strobe ignored
      strobe();
      check(trim_code == 12'hA5C && !busy, "R5", trim_code, 12'hA5C);

      // random targets
      for (int k = 0; k < 6; k++) begin
         tgt = int'($urandom() & 12'hFFF);
         run_cal(tgt, k[0], 1'b0);
         duty = int'($urandom_range(0, PER));
         user_duty = CW'(duty);
         measure_high(duty, "R10 duty");
         check(int'(trim_code) == tgt, "R10 hold", trim_code, tgt);
      end

      user_duty = CW'(0);
      measure_high(0, "R10 zero");
      user_duty = CW'(PER);
      measure_high(PER, "R10 full");

      // synchronizer latency: flip comparator on the strobe cycle
      start_cal();
      tick(); cmp_raw = 1'b1;
      repeat (4) tick();
      tick(); cmp_raw = 1'b0; cycle_done = 1'b1;
      tick(); cycle_done = 1'b0;
      check(trim_code == 12'hC00, "R8 late", trim_code, 12'hC00);
      repeat (4) tick();
      strobe();
      check(trim_code == 12'hA00, "R8 settled", trim_code, 12'hA00);
      for (int b = 9; b >= 0; b--) begin
         repeat (3) tick();
         strobe();
      end
      check(trim_code == 12'h800 && !busy, "R8 final", trim_code, 12'h800);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule